// File: doc/BRIEF.md
# Magic-Pattern Register Write Lock

This block is a write filter placed between the front end that decodes serial register accesses and the register storage behind it. Each completed register write (an 8-bit pointer and a 16-bit value) arrives on a valid/ready input stream. The block decides whether that write reaches storage or is silently dropped. The decision depends on a lock mode, which is set by writing particular 16-bit patterns to a lock register that the block holds at pointer 0xFE. The purpose is to make a spurious, noise-induced write unlikely to change protected settings.

There are three modes. In the open mode every write is forwarded. In the full-lock mode every write is dropped. In the orientation-lock mode only writes to the two image-orientation registers are dropped. Writes to the lock register itself are always taken in. They update the readback value and, when the value is one of the three patterns, the mode. They are never forwarded to storage.

Forwarded writes leave on a registered valid/ready output stream with one cycle of latency. Back-pressure rules are as follows. An input beat is accepted when `wr_valid` and `wr_ready` are both high. `wr_ready` is high whenever the output holds nothing, or the held beat is being taken in the same cycle. While `commit_valid` is high and `commit_ready` is low, the output beat holds steady and `wr_ready` is low. A dropped beat is still accepted; it simply produces no output beat.

Top module: `wlock_filter`

## Requirements
- R1: After reset `lock_value` reads 0xBEEF, the mode is open, and `commit_valid` is low.
- R2: In the open mode, an accepted write to any pointer other than 0xFE appears on `commit_valid`/`commit_addr`/`commit_data` in the cycle after acceptance, with the same pointer and value.
- R3: An accepted write to pointer 0xFE is taken in whatever the mode. `lock_value` shows the written value in the cycle after acceptance, and the write is never presented on the commit output.
- R4: After 0xDEAD is written to 0xFE, every accepted write to any other pointer is dropped: `commit_valid` stays low in the following cycle.
- R5: After 0xDEAF is written to 0xFE, accepted writes to pointers 0x0D and 0x0E are dropped, and writes to every other pointer except 0xFE are forwarded as in R2.
- R6: After 0xBEEF is written to 0xFE, the open mode of R2 applies again from any locked mode.
- R7: Writing any value other than 0xBEEF, 0xDEAD or 0xDEAF to 0xFE changes `lock_value` but leaves the lock mode as it was.
- R8: A mode change takes effect for the write accepted in the cycle right after the lock-register write, including back-to-back beats.
- R9: While `commit_valid` is high and `commit_ready` is low, `wr_ready` is low and `commit_valid`, `commit_addr` and `commit_data` hold their values on the next cycle.
- R10: A dropped write leaves `commit_valid` low in the cycle after its acceptance and does not change `lock_value`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Completed register write is offered |
| wr_ready | output | 1 | Block accepts the offered write this cycle |
| wr_addr | input | 8 | Register pointer of the write |
| wr_data | input | 16 | Value of the write |
| commit_valid | output | 1 | Forwarded write toward storage is present |
| commit_ready | input | 1 | Storage takes the forwarded write |
| commit_addr | output | 8 | Pointer of the forwarded write |
| commit_data | output | 16 | Value of the forwarded write |
| lock_value | output | 16 | Current lock register contents for readback |

## Verification
The hardest case to reach from the ports is a lock-register write followed in the very next cycle by a write that the new mode must block or release. A stall on the output also has to land on top of a pending forwarded beat. Random stimulus biases the pointer heavily toward 0xFE, 0x0D and 0x0E and the lock value toward the three patterns, so that mode flips, back-to-back beats and unrecognised values occur often. Directed sequences hold `commit_ready` low across an offered beat and then release it, and write an unrecognised value while fully locked.

// File: rtl/wlock_pkg.sv
package wlock_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN        = 2'd0,
    MODE_LOCK_ALL    = 2'd1,
    MODE_LOCK_ORIENT = 2'd2
  } lock_mode_e;
endpackage

// File: rtl/wlock_mode_reg.sv
module wlock_mode_reg
  import wlock_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] OPEN_KEY   = 16'hBEEF,
  parameter logic [DATA_W-1:0] ALL_KEY    = 16'hDEAD,
  parameter logic [DATA_W-1:0] ORIENT_KEY = 16'hDEAF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [DATA_W-1:0] upd_data,
  output lock_mode_e        mode,
  output logic [DATA_W-1:0] value
);
  lock_mode_e next_mode;

  // Only the three patterns move the mode; anything else keeps it.
  always_comb begin
    next_mode = mode;
    if (upd) begin
      if (upd_data == OPEN_KEY)        next_mode = MODE_OPEN;
      else if (upd_data == ALL_KEY)    next_mode = MODE_LOCK_ALL;
      else if (upd_data == ORIENT_KEY) next_mode = MODE_LOCK_ORIENT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= MODE_OPEN;
      value <= OPEN_KEY;
    end else begin
      mode <= next_mode;
      if (upd) value <= upd_data;
    end
  end
endmodule

// File: rtl/wlock_gate.sv
module wlock_gate
  import wlock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_PROT = 2,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST = {8'h0E, 8'h0D},
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hFE
) (
  input  lock_mode_e        mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              is_lock_reg,
  output logic              pass
);
  logic [NUM_PROT-1:0] hit;

  for (genvar g = 0; g < NUM_PROT; g++) begin : g_prot
    assign hit[g] = (addr == PROT_LIST[g*ADDR_W +: ADDR_W]);
  end

  assign is_lock_reg = (addr == LOCK_ADDR);

  always_comb begin
    pass = 1'b0;
    if (!is_lock_reg) begin
      unique case (mode)
        MODE_OPEN:        pass = 1'b1;
        MODE_LOCK_ORIENT: pass = ~(|hit);
        default:          pass = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wlock_commit_stage.sv
module wlock_commit_stage #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_pass,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= in_pass;
      if (in_pass) begin
        out_addr <= in_addr;
        out_data <= in_data;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wlock_filter.sv
module wlock_filter
  import wlock_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hFE,
  parameter logic [DATA_W-1:0] OPEN_KEY   = 16'hBEEF,
  parameter logic [DATA_W-1:0] ALL_KEY    = 16'hDEAD,
  parameter logic [DATA_W-1:0] ORIENT_KEY = 16'hDEAF,
  parameter int NUM_PROT = 2,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST = {8'h0E, 8'h0D}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              commit_valid,
  input  logic              commit_ready,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic [DATA_W-1:0] lock_value
);
  lock_mode_e cur_mode;
  logic       is_lock_reg;
  logic       pass;
  logic       lock_upd;

  // The lock register follows the same acceptance as every other write.
  assign lock_upd = wr_valid & wr_ready & is_lock_reg;

  wlock_gate #(
    .ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT),
    .PROT_LIST(PROT_LIST), .LOCK_ADDR(LOCK_ADDR)
  ) u_gate (
    .mode(cur_mode), .addr(wr_addr),
    .is_lock_reg(is_lock_reg), .pass(pass)
  );

  wlock_mode_reg #(
    .DATA_W(DATA_W), .OPEN_KEY(OPEN_KEY),
    .ALL_KEY(ALL_KEY), .ORIENT_KEY(ORIENT_KEY)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .upd(lock_upd), .upd_data(wr_data),
    .mode(cur_mode), .value(lock_value)
  );

  wlock_commit_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(wr_valid), .in_pass(pass), .in_addr(wr_addr), .in_data(wr_data),
    .in_ready(wr_ready),
    .out_valid(commit_valid), .out_ready(commit_ready),
    .out_addr(commit_addr), .out_data(commit_data)
  );
endmodule

// File: rtl/wlock_filter_chk.sv
module wlock_filter_chk
  import wlock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hFE,
  parameter logic [DATA_W-1:0] OPEN_KEY   = 16'hBEEF,
  parameter logic [DATA_W-1:0] ALL_KEY    = 16'hDEAD,
  parameter logic [DATA_W-1:0] ORIENT_KEY = 16'hDEAF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              commit_valid,
  input logic              commit_ready,
  input logic [ADDR_W-1:0] commit_addr,
  input logic [DATA_W-1:0] commit_data,
  input logic [DATA_W-1:0] lock_value,
  input lock_mode_e        cur_mode
);
  logic acc;
  assign acc = wr_valid & wr_ready;

  a_r3_never_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> commit_addr != LOCK_ADDR);

  a_r3_lock_update: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr_addr == LOCK_ADDR |=> lock_value == $past(wr_data));

  a_r2_open_forward: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cur_mode == MODE_OPEN && wr_addr != LOCK_ADDR |=>
      commit_valid && commit_addr == $past(wr_addr) && commit_data == $past(wr_data));

  a_r4_all_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cur_mode == MODE_LOCK_ALL |=> !commit_valid);

  a_r7_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr_addr == LOCK_ADDR && wr_data != OPEN_KEY && wr_data != ALL_KEY &&
      wr_data != ORIENT_KEY |=> cur_mode == $past(cur_mode));

  a_r9_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && !commit_ready |-> !wr_ready);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && !commit_ready |=>
      commit_valid && $stable(commit_addr) && $stable(commit_data));

  a_r10_value_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && wr_addr == LOCK_ADDR) |=> $stable(lock_value));
endmodule

bind wlock_filter wlock_filter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR),
  .OPEN_KEY(OPEN_KEY), .ALL_KEY(ALL_KEY), .ORIENT_KEY(ORIENT_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .commit_valid(commit_valid),
  .commit_ready(commit_ready), .commit_addr(commit_addr),
  .commit_data(commit_data), .lock_value(lock_value), .cur_mode(cur_mode)
);

// File: tb/wlock_filter_test.sv
`timescale 1ns/1ps
module wlock_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        commit_valid;
  logic        commit_ready = 1'b1;
  logic [7:0]  commit_addr;
  logic [15:0] commit_data;
  logic [15:0] lock_value;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Bench model: 0 open, 1 lock everything, 2 lock orientation registers
  int          m_mode = 0;
  logic [15:0] m_value = 16'hBEEF;

  always #2.5 clk = ~clk;

  wlock_filter uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit_valid(commit_valid),
    .commit_ready(commit_ready), .commit_addr(commit_addr),
    .commit_data(commit_data), .lock_value(lock_value)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_pass(input int mode, input logic [7:0] a);
    if (a == 8'hFE) return 0;
    if (mode == 1) return 0;
    if (mode == 2 && (a == 8'h0D || a == 8'h0E)) return 0;
    return 1;
  endfunction

  function automatic int next_mode(input int mode, input logic [15:0] d);
    if (d == 16'hBEEF) return 0;
    if (d == 16'hDEAD) return 1;
    if (d == 16'hDEAF) return 2;
    return mode;
  endfunction

  // One accepted write with the output free; result checked one edge later.
  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input string req);
    bit p;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; commit_ready = 1'b1;
    p = exp_pass(m_mode, a);
    @(posedge clk); #1;
    if (a == 8'hFE) begin
      m_value = d;
      m_mode  = next_mode(m_mode, d);
    end
    chk(commit_valid == p, req, {31'd0, commit_valid}, {31'd0, p});
    if (p) chk(commit_addr == a && commit_data == d, req,
               {8'd0, commit_addr, commit_data}, {8'd0, a, d});
    chk(lock_value == m_value, req, {16'd0, lock_value}, {16'd0, m_value});
  endtask

  task automatic idle();
    @(negedge clk);
    wr_valid = 1'b0;
    @(posedge clk); #1;
    chk(commit_valid == 1'b0, "R2 idle", {31'd0, commit_valid}, 32'd0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(lock_value == 16'hBEEF, "R1 reset value", {16'd0, lock_value}, 32'h0000BEEF);
    chk(commit_valid == 1'b0, "R1 reset commit", {31'd0, commit_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 open mode
    do_write(8'h0D, 16'h1111, "R2 open orient");
    do_write(8'h33, 16'hA5A5, "R2 open other");
    idle();
    // R4 lock all, with R8 back-to-back effect
    do_write(8'hFE, 16'hDEAD, "R3 lock write");
    do_write(8'h40, 16'h0284, "R8 R4 blocked next beat");
    do_write(8'h0E, 16'h0001, "R4 blocked orient");
    // R7 unrecognised value while locked; R10 lock value unchanged by drops
    do_write(8'hFE, 16'h1234, "R7 odd value");
    do_write(8'h22, 16'h5555, "R7 still locked");
    // R6 unlock then R5 orientation lock
    do_write(8'hFE, 16'hBEEF, "R6 unlock");
    do_write(8'h22, 16'h6666, "R6 open again");
    do_write(8'hFE, 16'hDEAF, "R5 orient lock");
    do_write(8'h0D, 16'h7777, "R5 blocked 0x0D");
    do_write(8'h0E, 16'h8888, "R5 blocked 0x0E");
    do_write(8'h0C, 16'h9999, "R5 neighbour 0x0C open");
    do_write(8'h0F, 16'hAAAA, "R5 neighbour 0x0F open");
    do_write(8'hFE, 16'h0000, "R7 odd value orient");
    do_write(8'h0D, 16'hBBBB, "R7 orient kept");
    do_write(8'h10, 16'hCCCC, "R10 after drop");
    do_write(8'hFE, 16'hBEEF, "R6 unlock 2");

    // R9 back-pressure
    @(negedge clk);
    commit_ready = 1'b0; wr_valid = 1'b1; wr_addr = 8'h21; wr_data = 16'h0A0A;
    @(posedge clk); #1;
    chk(commit_valid && commit_addr == 8'h21, "R9 first beat",
        {23'd0, commit_valid, commit_addr}, {23'd0, 1'b1, 8'h21});
    chk(wr_ready == 1'b0, "R9 ready low", {31'd0, wr_ready}, 32'd0);
    @(negedge clk);
    wr_addr = 8'h22; wr_data = 16'h0B0B;
    @(posedge clk); #1;
    chk(commit_valid && commit_addr == 8'h21 && commit_data == 16'h0A0A, "R9 hold",
        {7'd0, commit_valid, commit_addr, commit_data}, {7'd0, 1'b1, 8'h21, 16'h0A0A});
    @(negedge clk);
    commit_ready = 1'b1;
    @(posedge clk); #1;
    chk(commit_valid && commit_addr == 8'h22 && commit_data == 16'h0B0B, "R9 release",
        {7'd0, commit_valid, commit_addr, commit_data}, {7'd0, 1'b1, 8'h22, 16'h0B0B});
    idle();

    // Random mix biased toward the interesting pointers and patterns
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  a;
      logic [15:0] d;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 3)      a = 8'hFE;
      else if (sel < 5) a = 8'h0D;
      else if (sel < 7) a = 8'h0E;
      else              a = 8'($urandom);
      sel = int'($urandom_range(0, 4));
      if (sel == 0)      d = 16'hBEEF;
      else if (sel == 1) d = 16'hDEAD;
      else if (sel == 2) d = 16'hDEAF;
      else               d = 16'($urandom);
      do_write(a, d, "R8 random mix");
      if ($urandom_range(0, 7) == 0) idle();
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule